// File: doc/BRIEF.md
# Multi-cycle accumulator processor sequencer

This block is the control sequencer and datapath of a small processor that runs one instruction at a time. Each instruction passes through a fetch step, a decode step and then a short, fixed series of execute steps. The datapath holds an instruction pointer, an instruction register, two 8-bit general registers (A and B), a stack pointer, a 16-bit hold register for call targets, and an adder.

The block drives a single-port synchronous memory. It presents an address, write data and a write enable, and it receives read data one clock after the address. Five opcodes are decoded: load an immediate into A or into B, add B into A, push A, and call an absolute address. Any other opcode stops the sequencer until the next reset.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, the address bus shows 0, write enable is low and `halted` is low. Reset clears A and B to 0 and loads the stack pointer with 0x8000.
- R2: Every instruction's first cycle drives the instruction pointer onto the address bus with write enable low. The opcode read there is decoded in the next cycle, and the instruction pointer advances by one during that cycle.
- R3: Opcode 0x01 reads the byte after the opcode into A. The next fetch is two addresses past the opcode, four cycles after this fetch.
- R4: Opcode 0x02 does the same for B, with the same operand address and the same timing.
- R5: Opcode 0x03 replaces A with (A + B) mod 256 and leaves B unchanged. The next fetch follows three cycles after this fetch, at the next address.
- R6: Opcode 0x04 writes A to the address held in the stack pointer, two cycles after its fetch. The stack pointer then rises by one, so successive pushes fill ascending addresses. The next fetch comes one cycle after the write.
- R7: Opcode 0x05 reads a low byte and then a high byte from the two following addresses. Seven cycles after its fetch, it fetches from address {high, low}. It writes nothing to memory.
- R8: Any opcode other than 0x01 to 0x05 raises `halted`. From then on the address stays frozen and write enable stays low until reset.
- R9: Write enable rises only in the write cycle of a push, and only for a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data (register A) |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | High once an undefined opcode has been decoded |

## Verification
The push step does two things in one cycle: the memory write goes to the current stack pointer, and the stack pointer increments. If the increment happened a cycle early or late, the write would land on the wrong address. The bench provokes this with back-to-back pushes and with pushes mixed randomly among loads, adds and calls. For each write it compares the address, data and cycle against a stack pointer it keeps itself, so a gap, an overlap or a stale value in A is reported at the exact write.

// File: rtl/acc_seq_pkg.sv
// Shared types for the accumulator sequencer: step states, opcode
// values and the bundle of datapath strobes issued by the controller.
package acc_seq_pkg;

    localparam logic [7:0] OPC_LDA  = 8'h01;
    localparam logic [7:0] OPC_LDB  = 8'h02;
    localparam logic [7:0] OPC_ADD  = 8'h03;
    localparam logic [7:0] OPC_PUSH = 8'h04;
    localparam logic [7:0] OPC_CALL = 8'h05;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPADR,
        ST_OPCAP,
        ST_OPADR2,
        ST_OPCAP2,
        ST_JUMP,
        ST_ADD,
        ST_PUSH,
        ST_HALT
    } seq_state_t;

    typedef struct packed {
        logic ip_inc;
        logic ip_jump;
        logic a_imm;
        logic b_imm;
        logic a_sum;
        logic hold_lo;
        logic hold_hi;
        logic sp_inc;
        logic addr_sp;
        logic mem_wr;
    } ctl_t;

endpackage

// File: rtl/acc_seq_alu.sv
// Adder of the datapath. Assumes both operands share width W;
// the carry out is dropped, so the sum wraps modulo 2**W.
module acc_seq_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum
);
    // wrapping sum of the two operands
    always_comb sum = opa + opb;
endmodule

// File: rtl/acc_seq_ctrl.sv
// Step sequencer. Holds the instruction register and walks each opcode
// through its fixed step list. Assumes read data is valid one cycle
// after the address and that the opcode is on rd_data during DECODE.
module acc_seq_ctrl
    import acc_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rd_data,
    output seq_state_t    state_o,
    output ctl_t          ctl_o,
    output logic          halted_o
);
    seq_state_t    state_q, state_d;
    logic [DW-1:0] ir_q;
    logic          ir_ld;

    // step register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // instruction register, captured while decoding
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_ld) ir_q <= rd_data;
    end

    // next step and strobes for the current step
    always_comb begin
        ctl_o   = '0;
        ir_ld   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                ir_ld        = 1'b1;
                ctl_o.ip_inc = 1'b1;
                if (rd_data == DW'(OPC_LDA) || rd_data == DW'(OPC_LDB) ||
                    rd_data == DW'(OPC_CALL))
                    state_d = ST_OPADR;
                else if (rd_data == DW'(OPC_ADD))
                    state_d = ST_ADD;
                else if (rd_data == DW'(OPC_PUSH))
                    state_d = ST_PUSH;
                else
                    state_d = ST_HALT;
            end
            ST_OPADR:  state_d = ST_OPCAP;
            ST_OPCAP: begin
                ctl_o.ip_inc = 1'b1;
                if (ir_q == DW'(OPC_CALL)) begin
                    ctl_o.hold_lo = 1'b1;
                    state_d       = ST_OPADR2;
                end else begin
                    ctl_o.a_imm = (ir_q == DW'(OPC_LDA));
                    ctl_o.b_imm = (ir_q == DW'(OPC_LDB));
                    state_d     = ST_FETCH;
                end
            end
            ST_OPADR2: state_d = ST_OPCAP2;
            ST_OPCAP2: begin
                ctl_o.ip_inc  = 1'b1;
                ctl_o.hold_hi = 1'b1;
                state_d       = ST_JUMP;
            end
            ST_JUMP: begin
                ctl_o.ip_jump = 1'b1;
                state_d       = ST_FETCH;
            end
            ST_ADD: begin
                ctl_o.a_sum = 1'b1;
                state_d     = ST_FETCH;
            end
            ST_PUSH: begin
                ctl_o.addr_sp = 1'b1;
                ctl_o.mem_wr  = 1'b1;
                ctl_o.sp_inc  = 1'b1;
                state_d       = ST_FETCH;
            end
            default:   state_d = ST_HALT;
        endcase
    end

    assign state_o  = state_q;
    assign halted_o = (state_q == ST_HALT);
endmodule

// File: rtl/acc_seq_dpath.sv
// Register file and address path. Assumes AW == 2*DW so that a call
// target is exactly two words, low word first. The stack grows upward.
module acc_seq_dpath
    import acc_seq_pkg::*;
#(
    parameter int          DW      = 8,
    parameter int          AW      = 16,
    parameter int unsigned SP_INIT = 32'h8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic [AW-1:0] ip_o,
    output logic [AW-1:0] sp_o,
    output logic [DW-1:0] b_o,
    output logic [AW-1:0] hold_o
);
    localparam logic [AW-1:0] SP_RST = AW'(SP_INIT);

    logic [AW-1:0] ip_q, sp_q, hold_q;
    logic [DW-1:0] a_q, b_q, sum;

    acc_seq_alu #(.W(DW)) u_alu (.opa(a_q), .opb(b_q), .sum(sum));

    // instruction pointer: jump wins over increment
    always_ff @(posedge clk) begin
        if (!rst_n)           ip_q <= '0;
        else if (ctl.ip_jump) ip_q <= hold_q;
        else if (ctl.ip_inc)  ip_q <= ip_q + AW'(1);
    end

    // stack pointer, post-incremented by a push
    always_ff @(posedge clk) begin
        if (!rst_n)          sp_q <= SP_RST;
        else if (ctl.sp_inc) sp_q <= sp_q + AW'(1);
    end

    // register A: immediate load or adder result
    always_ff @(posedge clk) begin
        if (!rst_n)         a_q <= '0;
        else if (ctl.a_imm) a_q <= rd_data;
        else if (ctl.a_sum) a_q <= sum;
    end

    // register B: immediate load only
    always_ff @(posedge clk) begin
        if (!rst_n)         b_q <= '0;
        else if (ctl.b_imm) b_q <= rd_data;
    end

    // hold register collecting the two call operand words
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else begin
            if (ctl.hold_lo) hold_q[DW-1:0]  <= rd_data;
            if (ctl.hold_hi) hold_q[AW-1:DW] <= rd_data;
        end
    end

    // address source and write path
    always_comb begin
        addr  = ctl.addr_sp ? sp_q : ip_q;
        wdata = a_q;
        we    = ctl.mem_wr;
    end

    assign ip_o   = ip_q;
    assign sp_o   = sp_q;
    assign b_o    = b_q;
    assign hold_o = hold_q;
endmodule

// File: rtl/acc_seq_core.sv
// Top of the accumulator sequencer: controller plus datapath around a
// single-port synchronous memory with one cycle of read latency.
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int          DW      = 8,
    parameter int          AW      = 16,
    parameter int unsigned SP_INIT = 32'h8000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic          halted
);
    seq_state_t    state;
    ctl_t          ctl;
    logic [AW-1:0] ip_q, sp_q, hold_q;
    logic [DW-1:0] b_q;

    acc_seq_ctrl #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_data  (mem_rdata),
        .state_o  (state),
        .ctl_o    (ctl),
        .halted_o (halted)
    );

    acc_seq_dpath #(.DW(DW), .AW(AW), .SP_INIT(SP_INIT)) u_dpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .rd_data (mem_rdata),
        .addr    (mem_addr),
        .wdata   (mem_wdata),
        .we      (mem_we),
        .ip_o    (ip_q),
        .sp_o    (sp_q),
        .b_o     (b_q),
        .hold_o  (hold_q)
    );
endmodule

// File: rtl/acc_seq_chk.sv
// Property checker bound to acc_seq_core; observes ports and the
// registers between controller and datapath.
module acc_seq_chk
    import acc_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic          halted,
    input logic [AW-1:0] mem_addr,
    input seq_state_t    state,
    input logic [AW-1:0] ip_q,
    input logic [AW-1:0] sp_q,
    input logic [AW-1:0] hold_q,
    input logic [DW-1:0] b_q
);
    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> (mem_addr == ip_q && !mem_we));
    // R5
    add_keeps_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADD) |=> $stable(b_q));
    // R6
    push_sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_q == $past(sp_q) + AW'(1)));
    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JUMP) |=> (ip_q == $past(hold_q)));
    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(mem_addr)));
    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
    // R9
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
endmodule

bind acc_seq_core acc_seq_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .halted   (halted),
    .mem_addr (mem_addr),
    .state    (state),
    .ip_q     (ip_q),
    .sp_q     (sp_q),
    .hold_q   (hold_q),
    .b_q      (b_q)
);

// File: tb/tb_acc_seq_core.sv
// Bench: bench-side memory, instruction-level reference model that
// follows the design cycle by cycle, directed and seeded random programs.
module tb_acc_seq_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_we;
    logic        halted;

    logic [7:0]  mem [512];
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_seq_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .halted    (halted)
    );

    // sparse memory: low half of the map and the stack half alias by bit 15
    function automatic int idx(input logic [15:0] a);
        return int'({a[15], a[7:0]});
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[idx(mem_addr)] <= mem_wdata;
        mem_rdata <= mem[idx(mem_addr)];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // advance one cycle; no write is expected in it
    task automatic quiet(input string req);
        @(negedge clk);
        chk(mem_we == 1'b0, req, "unexpected write enable", int'(mem_we), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_addr == 16'h0 && !mem_we && !halted, "R1", "reset outputs",
            int'({mem_addr, mem_we, halted}), 0);
        rst_n = 1'b1;
        chk(mem_addr == 16'h0 && !mem_we && !halted, "R1", "first fetch after reset",
            int'({mem_addr, mem_we, halted}), 0);
    endtask

    // run up to n instructions from reset state, modelling each one
    task automatic run_prog(input int n);
        logic [15:0] ip = 16'h0000;
        logic [15:0] sp = 16'h8000;
        logic [7:0]  a  = 8'h00;
        logic [7:0]  b  = 8'h00;
        for (int k = 0; k < n; k++) begin
            logic [7:0] op, lo, hi;
            chk(mem_addr == ip, "R2", "fetch address", int'(mem_addr), int'(ip));
            chk(!mem_we, "R2", "write during fetch", int'(mem_we), 0);
            op = mem[idx(ip)];
            quiet("R9");
            case (op)
                8'h01, 8'h02: begin
                    quiet("R9");
                    chk(mem_addr == ip + 16'd1, (op == 8'h01) ? "R3" : "R4",
                        "operand address", int'(mem_addr), int'(ip + 16'd1));
                    quiet("R9");
                    quiet("R9");
                    if (op == 8'h01) a = mem[idx(ip + 16'd1)];
                    else             b = mem[idx(ip + 16'd1)];
                    ip = ip + 16'd2;
                end
                8'h03: begin
                    quiet("R5");
                    quiet("R5");
                    a  = a + b;
                    ip = ip + 16'd1;
                end
                8'h04: begin
                    @(negedge clk);
                    chk(mem_we == 1'b1, "R6", "push write enable", int'(mem_we), 1);
                    chk(mem_addr == sp, "R6", "push address", int'(mem_addr), int'(sp));
                    chk(mem_wdata == a, "R6", "pushed value", int'(mem_wdata), int'(a));
                    sp = sp + 16'd1;
                    quiet("R9");
                    ip = ip + 16'd1;
                end
                8'h05: begin
                    lo = mem[idx(ip + 16'd1)];
                    hi = mem[idx(ip + 16'd2)];
                    repeat (6) quiet("R7");
                    ip = {hi, lo};
                end
                default: begin
                    repeat (3) begin
                        quiet("R8");
                        chk(halted == 1'b1, "R8", "halted flag", int'(halted), 1);
                    end
                    return;
                end
            endcase
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=finish", 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        // directed 1: wrap on add, back-to-back pushes, call with high byte
        clear_mem();
        begin
            logic [7:0] p [15] = '{8'h01, 8'hFF, 8'h02, 8'h01, 8'h03, 8'h04,
                                   8'h04, 8'h02, 8'h10, 8'h03, 8'h03, 8'h04,
                                   8'h05, 8'h34, 8'h12};
            for (int i = 0; i < 15; i++) mem[i] = p[i];
        end
        mem[8'h34] = 8'h01; mem[8'h35] = 8'h7E; mem[8'h36] = 8'h04;
        mem[8'h37] = 8'hFF;
        do_reset();
        run_prog(50);
        // R6 pushes landed in ascending stack cells
        chk(mem[idx(16'h8000)] == 8'h00 && mem[idx(16'h8001)] == 8'h00, "R6",
            "stack cells 0,1", int'({mem[idx(16'h8000)], mem[idx(16'h8001)]}), 0);
        chk(mem[idx(16'h8002)] == 8'h20, "R6", "stack cell 2",
            int'(mem[idx(16'h8002)]), 8'h20);
        chk(mem[idx(16'h8003)] == 8'h7E, "R7", "push after call",
            int'(mem[idx(16'h8003)]), 8'h7E);

        // directed 2: undefined opcode 0x06 just past the defined range
        clear_mem();
        mem[0] = 8'h02; mem[1] = 8'h05; mem[2] = 8'h06;
        do_reset();
        run_prog(10);

        // directed 3: B untouched by two adds (R5), A reset to 0 (R1)
        clear_mem();
        mem[0] = 8'h04; mem[1] = 8'h01; mem[2] = 8'h05; mem[3] = 8'h02;
        mem[4] = 8'h07; mem[5] = 8'h03; mem[6] = 8'h03; mem[7] = 8'h04;
        mem[8] = 8'h00;
        do_reset();
        run_prog(10);
        chk(mem[idx(16'h8000)] == 8'h00, "R1", "A after reset",
            int'(mem[idx(16'h8000)]), 0);
        chk(mem[idx(16'h8001)] == 8'h13, "R5", "A+B+B",
            int'(mem[idx(16'h8001)]), 8'h13);

        // random programs
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 512; i++)
                mem[i] = ($urandom_range(0, 9) < 8) ? 8'($urandom_range(1, 5))
                                                    : 8'($urandom_range(0, 255));
            do_reset();
            run_prog(150);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule